// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block drives the four coil-enable lines of a four-phase stepper motor. One pulse on `start` begins a run of `step_count` steps. The run turns clockwise or counter-clockwise and uses one of three drive formats. In wave drive one coil is energized at a time. In two-phase drive two adjacent coils are energized. Half-step drive alternates between single-coil and paired-coil states. The clockwise and counter-clockwise directions each have their own step period, counted in ticks of a free-running prescaler. When the run ends, `busy` drops and `stop_pulse` fires for one cycle. The coil lines then settle into a parked state chosen by `hold_sel`, and an optional idle time-out can later force them to zero.

The first run after reset begins with an uncounted reference step, which places the rotor at a known coil. After that, the position persists across runs, so each new run continues from the last energized state. An auto-reverse option runs one leg in each direction. When the first leg was counter-clockwise, a programmable pause comes before the clockwise leg.

Top module: `stepper_phase_seq`

## Requirements
- R1: While reset is asserted and until the first accepted start, `coils` is 0000, `coil_oe` is 1, `busy` is 0, `steps_total` is 0 and `stop_pulse` is 0.
- R2: On the first accepted start after reset, the cycle after the start edge shows a reference pattern, and `steps_total` does not count it. Clockwise, the pattern is 0001 in wave or half-step and 0011 in two-phase. Counter-clockwise, it is 1000 in wave or half-step and 1100 in two-phase. Bit 0 of `coils` is the first coil.
- R3: A prescaler tick occurs every `TICK_DIV` clocks, free-running from reset. While running, a step occurs on the Nth tick after the start, or after the previous step. N is `cw_period` when turning clockwise and `ccw_period` when turning counter-clockwise, and a value of 0 acts as 1.
- R4: The clockwise wave order is 0001, 0010, 0100, 1000. The two-phase order is 0011, 0110, 1100, 1001. Half-step runs 0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001. Counter-clockwise reverses each order. `drive_mode` is 0 for wave, 1 for two-phase, and 2 or 3 for half-step. When the mode differs from the current state's kind, the step goes to the nearest state of the new kind in the direction of travel.
- R5: The coil position never changes while idle. A start after the first one applies no reference step and continues from the last position.
- R6: `steps_total` is a 32-bit counter that rises by exactly one per issued step. Only reset clears it.
- R7: After the last requested step, `busy` falls. In the first cycle with `busy` low, `stop_pulse` is high for exactly one cycle.
- R8: A start is ignored while `busy` is high, including during the reversal pause. A start is also ignored when `step_count` is 0.
- R9: With `auto_reverse` set, a clockwise start runs `step_count` steps clockwise and then at once `step_count` steps counter-clockwise. A counter-clockwise start runs its leg, waits `loop_delay` ticks (0 acts as 1) with `busy` high and the coils unchanged, and then runs `step_count` steps clockwise.
- R10: When idle after a run, `hold_sel` selects the parked output. 0 holds the last pattern. 1 drives 1111. 2 drives 0000. 3 drives 0000 with `coil_oe` low (released).
- R11: With `stop_timeout` nonzero, once that many ticks have passed while idle after a run, `coils` is 0000 and `coil_oe` is 1 until the next start. A time-out of 0 disables this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, one cycle |
| dir_ccw | input | 1 | 1 = counter-clockwise first leg |
| auto_reverse | input | 1 | Run a second leg in the opposite direction |
| drive_mode | input | 2 | 0 wave, 1 two-phase, 2/3 half-step |
| step_count | input | CNT_W | Steps per leg |
| cw_period | input | PER_W | Clockwise step period in ticks |
| ccw_period | input | PER_W | Counter-clockwise step period in ticks |
| loop_delay | input | PER_W | Pause in ticks before the clockwise leg after a counter-clockwise one |
| hold_sel | input | 2 | Parked output selection |
| stop_timeout | input | TO_W | Idle ticks before outputs drop to zero, 0 = never |
| coils | output | 4 | Coil enables, bit 0 = first coil |
| coil_oe | output | 1 | Output enable, low when released |
| busy | output | 1 | Run or reversal pause in progress |
| steps_total | output | 32 | Steps issued since reset |
| stop_pulse | output | 1 | One-cycle pulse when a run ends |

## Verification
The reference pattern and the busy flag are due one clock after the start edge. A step appears one clock after the prescaler tick that completes its period, and `stop_pulse` shows in the same cycle that `busy` first reads low. Parked and released outputs follow `hold_sel` combinationally in the same cycle. The bench model advances on each rising edge from the same sampled inputs, and every output is compared with it at the following falling edge. Directed checks wait on `busy` and sample at the falling edge, so they never race a pending register update.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LOOP = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PARK_LAST    = 2'd0,
    PARK_ALL_ON  = 2'd1,
    PARK_ALL_OFF = 2'd2,
    PARK_FLOAT   = 2'd3
  } park_e;

  // Positions 0..7 on the half-step grid: even = one coil, odd = coil pair.
  function automatic logic [2:0] next_pos(logic [2:0] p, logic ccw, logic [1:0] m);
    case (m)
      2'd0:    return ccw ? ((p - 3'd1) & 3'd6) : ((p + 3'd2) & 3'd6);
      2'd1:    return ccw ? ((p - 3'd2) | 3'd1) : ((p + 3'd1) | 3'd1);
      default: return ccw ? (p - 3'd1) : (p + 3'd1);
    endcase
  endfunction

  function automatic logic [2:0] ref_pos(logic ccw, logic [1:0] m);
    if (m == 2'd1) return ccw ? 3'd5 : 3'd1;
    return ccw ? 3'd6 : 3'd0;
  endfunction

  function automatic logic [3:0] coil_pattern(logic [2:0] p);
    logic [3:0] one;
    one = 4'b0001 << p[2:1];
    if (p[0]) return one | {one[2:0], one[3]};
    return one;
  endfunction

endpackage

// File: rtl/sps_tick_gen.sv
module sps_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LAST = (DIV > 1) ? DIV - 1 : 0;

  logic [W-1:0] cnt;

  assign tick = (cnt == W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sps_interval.sv
module sps_interval #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim_m1;

  assign lim_m1 = (limit == '0) ? '0 : limit - 1'b1;
  assign done   = en && tick && (cnt == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (en && tick) cnt <= done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sps_park.sv
module sps_park
  import sps_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          ran_once,
  input  logic          tick,
  input  logic [1:0]    hold_sel,
  input  logic [TW-1:0] timeout,
  input  logic [3:0]    run_pattern,
  output logic [3:0]    coils,
  output logic          coil_oe
);
  logic [TW-1:0] idle_ticks;
  logic          expired;

  assign expired = (timeout != '0) && (idle_ticks >= timeout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           idle_ticks <= '0;
    else if (busy)                        idle_ticks <= '0;
    else if (tick && idle_ticks < timeout) idle_ticks <= idle_ticks + 1'b1;
  end

  always_comb begin
    coils   = 4'b0000;
    coil_oe = 1'b1;
    if (!ran_once)    coils = 4'b0000;
    else if (busy)    coils = run_pattern;
    else if (expired) coils = 4'b0000;
    else begin
      case (park_e'(hold_sel))
        PARK_LAST:    coils = run_pattern;
        PARK_ALL_ON:  coils = 4'b1111;
        PARK_ALL_OFF: coils = 4'b0000;
        default: begin
          coils   = 4'b0000;
          coil_oe = 1'b0;
        end
      endcase
    end
  end

  // R10
  released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coil_oe |-> (coils == 4'b0000));

  // R11
  expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> !busy);
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import sps_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int CNT_W    = 16,
  parameter int PER_W    = 16,
  parameter int TO_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_ccw,
  input  logic             auto_reverse,
  input  logic [1:0]       drive_mode,
  input  logic [CNT_W-1:0] step_count,
  input  logic [PER_W-1:0] cw_period,
  input  logic [PER_W-1:0] ccw_period,
  input  logic [PER_W-1:0] loop_delay,
  input  logic [1:0]       hold_sel,
  input  logic [TO_W-1:0]  stop_timeout,
  output logic [3:0]       coils,
  output logic             coil_oe,
  output logic             busy,
  output logic [31:0]      steps_total,
  output logic             stop_pulse
);
  seq_state_e       state;
  logic [2:0]       pos;
  logic [CNT_W-1:0] remaining;
  logic             leg_ccw;
  logic             rev_pending;
  logic             ran_once;

  logic             tick;
  logic             in_run, in_loop;
  logic             accept;
  logic [PER_W-1:0] limit;
  logic             iv_done;
  logic             step_evt, loop_end, last_step;

  assign in_run    = (state == ST_RUN);
  assign in_loop   = (state == ST_LOOP);
  assign busy      = (state != ST_IDLE);
  assign accept    = (state == ST_IDLE) && start && (step_count != '0);
  assign limit     = in_loop ? loop_delay : (leg_ccw ? ccw_period : cw_period);
  assign step_evt  = in_run && iv_done;
  assign loop_end  = in_loop && iv_done;
  assign last_step = step_evt && (remaining == CNT_W'(1));

  sps_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sps_interval #(.W(PER_W)) u_interval (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(in_run || in_loop),
    .tick(tick), .limit(limit), .done(iv_done)
  );

  sps_park #(.TW(TO_W)) u_park (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ran_once(ran_once), .tick(tick),
    .hold_sel(hold_sel), .timeout(stop_timeout), .run_pattern(coil_pattern(pos)),
    .coils(coils), .coil_oe(coil_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pos         <= 3'd0;
      remaining   <= '0;
      leg_ccw     <= 1'b0;
      rev_pending <= 1'b0;
      ran_once    <= 1'b0;
      steps_total <= '0;
      stop_pulse  <= 1'b0;
    end else begin
      stop_pulse <= 1'b0;
      if (accept) begin
        state       <= ST_RUN;
        leg_ccw     <= dir_ccw;
        remaining   <= step_count;
        rev_pending <= auto_reverse;
        ran_once    <= 1'b1;
        if (!ran_once) pos <= ref_pos(dir_ccw, drive_mode);
      end
      if (step_evt) begin
        pos         <= next_pos(pos, leg_ccw, drive_mode);
        steps_total <= steps_total + 32'd1;
        remaining   <= remaining - 1'b1;
        if (last_step) begin
          if (rev_pending) begin
            rev_pending <= 1'b0;
            if (leg_ccw) state <= ST_LOOP;
            else begin
              leg_ccw   <= 1'b1;
              remaining <= step_count;
            end
          end else begin
            state      <= ST_IDLE;
            stop_pulse <= 1'b1;
          end
        end
      end
      if (loop_end) begin
        state     <= ST_RUN;
        leg_ccw   <= 1'b0;
        remaining <= step_count;
      end
    end
  end

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !busy);

  // R7
  busy_fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> stop_pulse);

  // R6
  total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steps_total != $past(steps_total)) |-> (steps_total == $past(steps_total) + 32'd1));

  // R4
  coil_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(coils) == 1 || $countones(coils) == 2));

  // R5
  idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(pos));

  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !step_evt) |=> $stable(remaining));
endmodule

// File: tb/stepper_phase_seq_bench.sv
module stepper_phase_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_ccw = 1'b0;
  logic        auto_reverse = 1'b0;
  logic [1:0]  drive_mode = 2'd0;
  logic [15:0] step_count = 16'd0;
  logic [15:0] cw_period = 16'd2;
  logic [15:0] ccw_period = 16'd3;
  logic [15:0] loop_delay = 16'd5;
  logic [1:0]  hold_sel = 2'd0;
  logic [15:0] stop_timeout = 16'd0;
  logic [3:0]  coils;
  logic        coil_oe, busy, stop_pulse;
  logic [31:0] steps_total;

  int checks = 0;
  int failures = 0;
  bit done_run = 1'b0;

  stepper_phase_seq u_stepper_phase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_ccw(dir_ccw),
    .auto_reverse(auto_reverse), .drive_mode(drive_mode), .step_count(step_count),
    .cw_period(cw_period), .ccw_period(ccw_period), .loop_delay(loop_delay),
    .hold_sel(hold_sel), .stop_timeout(stop_timeout), .coils(coils),
    .coil_oe(coil_oe), .busy(busy), .steps_total(steps_total), .stop_pulse(stop_pulse)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_pc, m_state, m_pos, m_rem, m_cnt, m_to;
  bit  m_dir, m_pend, m_ran, m_stop;
  longint m_tot;

  function automatic int m_pat(int p);
    case (p)
      0: return 1;  1: return 3;  2: return 2;  3: return 6;
      4: return 4;  5: return 12; 6: return 8;  default: return 9;
    endcase
  endfunction

  function automatic int m_move(int p, bit ccw, int mode);
    int q = p;
    do q = ccw ? (q + 7) % 8 : (q + 1) % 8;
    while ((mode == 0 && q % 2 != 0) || (mode == 1 && q % 2 != 1));
    return q;
  endfunction

  function automatic int m_ref(bit ccw, int mode);
    if (mode == 1) return ccw ? 5 : 1;
    return ccw ? 6 : 0;
  endfunction

  function automatic int at_least1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_state = 0; m_pos = 0; m_rem = 0; m_cnt = 0; m_to = 0;
      m_dir = 0; m_pend = 0; m_ran = 0; m_stop = 0; m_tot = 0;
    end else begin
      bit tk;
      tk = (m_pc == DIV - 1);
      m_pc = (m_pc + 1) % DIV;
      m_stop = 0;
      if (m_state != 0) m_to = 0;
      else if (tk && m_to < int'(stop_timeout)) m_to++;
      if (m_state == 0) begin
        if (start && step_count != 0) begin
          m_state = 1; m_dir = dir_ccw; m_rem = step_count;
          m_pend = auto_reverse; m_cnt = 0;
          if (!m_ran) begin m_pos = m_ref(dir_ccw, drive_mode); m_ran = 1; end
        end
      end else if (tk) begin
        int lim;
        lim = (m_state == 2) ? at_least1(loop_delay)
                             : at_least1(m_dir ? ccw_period : cw_period);
        if (m_cnt == lim - 1) begin
          m_cnt = 0;
          if (m_state == 2) begin
            m_state = 1; m_dir = 0; m_rem = step_count;
          end else begin
            m_pos = m_move(m_pos, m_dir, drive_mode);
            m_tot = (m_tot + 1) % 64'h1_0000_0000;
            if (m_rem == 1) begin
              if (m_pend && !m_dir) begin m_pend = 0; m_dir = 1; m_rem = step_count; end
              else if (m_pend) begin m_pend = 0; m_state = 2; end
              else begin m_state = 0; m_stop = 1; end
            end else m_rem--;
          end
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      int ec, eo;
      eo = 1;
      if (!m_ran) ec = 0;
      else if (m_state != 0) ec = m_pat(m_pos);
      else if (stop_timeout != 0 && m_to >= int'(stop_timeout)) ec = 0;
      else case (hold_sel)
        2'd0: ec = m_pat(m_pos);
        2'd1: ec = 15;
        2'd2: ec = 0;
        default: begin ec = 0; eo = 0; end
      endcase
      chk(coils == 4'(ec), "R4", coils, ec);
      chk(coil_oe == 1'(eo), "R10", coil_oe, eo);
      chk(busy == (m_state != 0), "R9", busy, m_state != 0);
      chk(steps_total == 32'(m_tot), "R3", steps_total, m_tot);
      chk(stop_pulse == m_stop, "R7", stop_pulse, m_stop);
    end
  end

  // ---------------- stimulus ----------------
  task automatic kick(input bit ccw, input bit rev, input logic [1:0] mode, input int n);
    @(negedge clk);
    dir_ccw = ccw; auto_reverse = rev; drive_mode = mode; step_count = 16'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(coils == 4'b0000 && coil_oe && !busy, "R1", {coils, coil_oe, busy}, 6'b000010);
    chk(steps_total == 0 && !stop_pulse, "R1", steps_total, 0);

    // Clockwise wave, 4 steps
    kick(1'b0, 1'b0, 2'd0, 4);
    chk(coils == 4'b0001, "R2", coils, 4'b0001);
    chk(steps_total == 0, "R2", steps_total, 0);
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // R8 ignored while running
    wait_idle();
    chk(stop_pulse == 1'b1, "R7", stop_pulse, 1);
    chk(steps_total == 4, "R8", steps_total, 4);
    chk(coils == 4'b0001, "R4", coils, 4'b0001);

    // Zero step count is ignored
    kick(1'b0, 1'b0, 2'd0, 0);
    chk(!busy, "R8", busy, 0);

    // Counter-clockwise two-phase, 3 steps, no reference step
    kick(1'b1, 1'b0, 2'd1, 3);
    chk(coils == 4'b0001, "R5", coils, 4'b0001);
    wait_idle();
    chk(coils == 4'b0110, "R4", coils, 4'b0110);
    chk(steps_total == 7, "R6", steps_total, 7);

    // Clockwise half-step, 3 steps, parked states
    hold_sel = 2'd1;
    kick(1'b0, 1'b0, 2'd2, 3);
    wait_idle();
    chk(coils == 4'b1111, "R10", coils, 4'b1111);
    @(negedge clk); hold_sel = 2'd3; #1;
    chk(coils == 4'b0000 && !coil_oe, "R10", {coils, coil_oe}, 5'b00000);
    hold_sel = 2'd2; #1;
    chk(coils == 4'b0000 && coil_oe, "R10", {coils, coil_oe}, 5'b00001);
    hold_sel = 2'd0; #1;
    chk(coils == 4'b1000, "R5", coils, 4'b1000);

    // Idle time-out
    hold_sel = 2'd1; stop_timeout = 16'd3;
    kick(1'b0, 1'b0, 2'd0, 1);
    wait_idle();
    chk(coils == 4'b1111, "R11", coils, 4'b1111);
    repeat (4 * DIV) @(negedge clk);
    chk(coils == 4'b0000 && coil_oe, "R11", {coils, coil_oe}, 5'b00001);
    stop_timeout = 16'd0; #1;
    chk(coils == 4'b1111, "R11", coils, 4'b1111);
    hold_sel = 2'd0;

    // Auto reverse from counter-clockwise with pause
    kick(1'b1, 1'b1, 2'd0, 2);
    wait_idle();
    chk(coils == 4'b0001, "R9", coils, 4'b0001);
    chk(steps_total == 15, "R9", steps_total, 15);

    // Auto reverse from clockwise, half-step
    kick(1'b0, 1'b1, 2'd2, 2);
    wait_idle();
    chk(coils == 4'b0001, "R9", coils, 4'b0001);
    chk(steps_total == 19, "R6", steps_total, 19);

    // Zero period acts as one tick
    cw_period = 16'd0;
    kick(1'b0, 1'b0, 2'd0, 2);
    wait_idle();
    chk(coils == 4'b0100, "R3", coils, 4'b0100);
    chk(steps_total == 21, "R3", steps_total, 21);

    repeat (3) @(negedge clk);
    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      done_run = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule